// File: doc/BRIEF.md
# Factory Bad-Block Table Scanner

After power-up this block walks through every erase block of a NAND flash array and builds a one-bit-per-block map of the blocks the factory marked as unusable. For each block it asks for a single byte: the marker byte in the spare area of the block's first page. If that byte reads FFh it then asks for the same byte of the second page. A block is flagged when either byte differs from FFh. Block 0 is always usable, so it is never read.

Byte reads go through a plain request/acknowledge port that a flash bus sequencer serves. The block presents a page row address and a column offset inside the spare area, and holds them until the sequencer returns the byte with an acknowledge. When the last block has been judged, `done` rises. The map can then be read by block number, and the count of flagged blocks is available. A flag signals an anomalous count, because a healthy part has no more than 35 bad blocks.

Top module: `bad_block_scanner`

## Requirements
- R1: While reset is held and after it is released, `done` is 0, `rd_req` is 0 and `bad_count` is 0.
- R2: Every read request presents `rd_spare_col` = 5 (the sixth spare byte, column 517) and `rd_row` = block × 32 + page.
- R3: Blocks are visited in ascending order from block 1 to block 2047. Page 0 is read first. Page 1 is read only when page 0 returned FFh.
- R4: After the scan, `tbl_bad` is 1 for exactly those blocks whose page 0 or page 1 marker byte was not FFh, and 0 for all others.
- R5: Block 0 is never read (no request has `rd_row` below 32), and its map entry reads 0.
- R6: `bad_count` equals the number of flagged blocks. It is 11 bits wide, so it can count up to 2047 (every block other than block 0 bad).
- R7: `anomaly` is 1 exactly when `bad_count` exceeds 35.
- R8: `done` rises in the cycle after the acknowledge of the final read and stays high until the next start. `rd_req` is 0 whenever `done` is 1.
- R9: A `start` pulse while a scan is running has no effect. A `start` after completion clears the map, the count and `done`, and begins a new scan.
- R10: Once raised, `rd_req` stays high with an unchanged `rd_row` until `rd_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (ignored while one runs) |
| rd_req | output | 1 | Read request to the bus sequencer |
| rd_row | output | 16 | Page row address: block × 32 + page |
| rd_spare_col | output | 4 | Byte offset within the spare area |
| rd_ack | input | 1 | Sequencer returns the requested byte this cycle |
| rd_data | input | 8 | Returned byte, valid with `rd_ack` |
| tbl_addr | input | 11 | Block number used to look up the map |
| tbl_bad | output | 1 | Map entry for `tbl_addr` (1 = bad) |
| done | output | 1 | Scan complete, map valid |
| bad_count | output | 11 | Number of bad blocks found |
| anomaly | output | 1 | Bad count above the guaranteed limit |

## Verification
The assertions assume that the sequencer raises `rd_ack` only while `rd_req` is high, and for one cycle per request. The stimulus serves requests from a single responder that acknowledges each request once, after a latency of zero to two cycles that depends on the row. The assertions also assume that `start` is not asserted in the same cycle as reset. The bench drives `start` only after reset has been released, and pulses it once in the middle of a scan to exercise the ignore rule.

// File: rtl/bad_block_scanner.sv
module bad_block_scanner #(
  parameter int NUM_BLOCKS = 2048,
  parameter int PAGES      = 32,
  parameter int MARK_COL   = 5,
  parameter int BAD_LIMIT  = 35,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int PG_W  = $clog2(PAGES),
  localparam int ROW_W = BLK_W + PG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             rd_req,
  output logic [ROW_W-1:0] rd_row,
  output logic [3:0]       rd_spare_col,
  input  logic             rd_ack,
  input  logic [7:0]       rd_data,
  input  logic [BLK_W-1:0] tbl_addr,
  output logic             tbl_bad,
  output logic             done,
  output logic [BLK_W-1:0] bad_count,
  output logic             anomaly
);
  logic                  busy;
  logic                  page;
  logic [BLK_W-1:0]      blk;
  logic [NUM_BLOCKS-1:0] bad_map;

  wire marker_bad = rd_data != 8'hFF;
  wire last_blk   = blk == BLK_W'(NUM_BLOCKS - 1);

  assign rd_req       = busy;
  assign rd_row       = {blk, {(PG_W-1){1'b0}}, page};
  assign rd_spare_col = 4'(MARK_COL);
  assign tbl_bad      = bad_map[tbl_addr];
  assign anomaly      = bad_count > BLK_W'(BAD_LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      page      <= 1'b0;
      blk       <= '0;
      bad_count <= '0;
      bad_map   <= '0;
    end else if (start && !busy) begin
      busy      <= 1'b1;
      done      <= 1'b0;
      page      <= 1'b0;
      blk       <= BLK_W'(1);
      bad_count <= '0;
      bad_map   <= '0;
    end else if (busy && rd_ack) begin
      if (marker_bad) begin
        bad_map[blk] <= 1'b1;
        if (bad_count != '1) bad_count <= bad_count + 1'b1;
      end
      if (marker_bad || page) begin
        page <= 1'b0;
        if (last_blk) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          blk <= blk + 1'b1;
        end
      end else begin
        page <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bad_block_scanner_chk.sv
module bad_block_scanner_chk #(
  parameter int BLK_W = 11,
  parameter int PG_W  = 5,
  parameter int PAGES = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rd_req,
  input logic [BLK_W+PG_W-1:0] rd_row,
  input logic                  rd_ack,
  input logic                  done,
  input logic [BLK_W-1:0]      bad_count
);
  p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_row)));

  p_idle_when_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);

  p_skip_block0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_row >= (BLK_W+PG_W)'(PAGES)));

  p_two_pages_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_row[PG_W-1:0] <= PG_W'(1)));

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bad_count == $past(bad_count) ||
              bad_count == BLK_W'($past(bad_count) + 1'b1) ||
              bad_count == '0));
endmodule

bind bad_block_scanner bad_block_scanner_chk #(
  .BLK_W(BLK_W), .PG_W(PG_W), .PAGES(PAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_row(rd_row),
  .rd_ack(rd_ack), .done(done), .bad_count(bad_count)
);

// File: tb/tb_bad_block_scanner.sv
module tb_bad_block_scanner;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rd_req;
  logic [15:0] rd_row;
  logic [3:0]  rd_spare_col;
  logic        rd_ack = 1'b0;
  logic [7:0]  rd_data = 8'h00;
  logic [10:0] tbl_addr = '0;
  logic        tbl_bad;
  logic        done;
  logic [10:0] bad_count;
  logic        anomaly;

  int checks = 0;
  int errors = 0;
  int scen = 0;
  int exp_q[$];
  int lat_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bad_block_scanner dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .rd_row(rd_row),
    .rd_spare_col(rd_spare_col), .rd_ack(rd_ack), .rd_data(rd_data),
    .tbl_addr(tbl_addr), .tbl_bad(tbl_bad), .done(done),
    .bad_count(bad_count), .anomaly(anomaly)
  );

  function automatic logic [7:0] marker(int s, int b, int p);
    if (b == 0) return 8'h00;
    case (s)
      0: begin
        if (p == 0 && b % 7 == 3) return 8'h00;
        if (p == 1 && b % 11 == 5) return 8'h5A;
        return 8'hFF;
      end
      1: begin
        if (p == 0 && b == 1) return 8'h00;
        if (p == 1 && b == NB - 1) return 8'hFE;
        if (p == 0 && b == 700) return 8'h7F;
        return 8'hFF;
      end
      default: return 8'h3C;
    endcase
  endfunction

  function automatic bit blk_bad(int s, int b);
    if (b == 0) return 1'b0;
    return marker(s, b, 0) != 8'hFF || marker(s, b, 1) != 8'hFF;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Responder and per-clock comparison against the expected request queue
  initial begin
    forever begin
      @(negedge clk);
      rd_ack = 1'b0;
      if (rd_req) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected request", int'(rd_row), -1);
        end else begin
          check(int'(rd_row) == exp_q[0], "R3 row order", int'(rd_row), exp_q[0]);
          check(rd_row >= 16'd32, "R5 block0 read", int'(rd_row), 32);
          check(rd_spare_col == 4'd5, "R2 spare column", int'(rd_spare_col), 5);
          if (lat_cnt >= exp_q[0] % 3) begin
            rd_ack = 1'b1;
            rd_data = marker(scen, exp_q[0] / 32, exp_q[0] % 32);
            void'(exp_q.pop_front());
            lat_cnt = 0;
          end else begin
            lat_cnt++;
          end
        end
      end
    end
  end

  task automatic run_scan(int s, bit poke);
    int exp_cnt = 0;
    int cyc = 0;
    scen = s;
    for (int b = 1; b < NB; b++) begin
      exp_q.push_back(b * 32);
      if (marker(s, b, 0) == 8'hFF) exp_q.push_back(b * 32 + 1);
      if (blk_bad(s, b)) exp_cnt++;
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(done == 1'b0, "R9 done cleared", int'(done), 0);
    check(rd_req == 1'b1, "R9 scan begun", int'(rd_req), 1);
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 500) start = 1'b1;
      if (poke && cyc == 501) start = 1'b0;
    end
    check(exp_q.size() == 0, "R3 all reads issued", exp_q.size(), 0);
    check(rd_req == 1'b0, "R8 no request when done", int'(rd_req), 0);
    check(int'(bad_count) == exp_cnt, "R6 bad count", int'(bad_count), exp_cnt);
    check(anomaly == (exp_cnt > 35), "R7 anomaly", int'(anomaly), int'(exp_cnt > 35));
    for (int b = 0; b < NB; b++) begin
      tbl_addr = 11'(b);
      #1;
      check(tbl_bad == blk_bad(s, b), b == 0 ? "R5 block0 entry" : "R4 map entry",
            int'(tbl_bad), int'(blk_bad(s, b)));
    end
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R8 done held", int'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0 && rd_req == 1'b0 && bad_count == 0, "R1 reset state",
          int'({done, rd_req}) + int'(bad_count), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0 && rd_req == 1'b0 && bad_count == 0, "R1 after reset",
          int'({done, rd_req}) + int'(bad_count), 0);
    run_scan(0, 1'b1);
    run_scan(1, 1'b0);
    run_scan(2, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule